// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Decoder

This block is the bus-facing front end of a digitally controlled potentiometer. It watches a two-wire serial bus (SCL and SDA) through synchronisers clocked by a fast system clock. It finds start and stop conditions and takes in an identification byte and an instruction byte. Depending on the command, it then receives one data byte from the master or returns one data byte to it. The block drives SDA only through an open-drain enable, for acknowledges and read data.

The decoded command reaches the wiper register and the data register file as single-cycle strobes. A register pointer and a bank pointer go with each strobe. A write data byte is also provided, and read data is taken back on a parallel input. One command puts the bus into a stepping mode. In that mode every further SCL clock moves the wiper one position up or down, and the mode lasts until a stop condition.

Top module: `dpot_cmd_decoder`

## Requirements
- R1: A falling SDA while SCL is high is a start and a rising SDA while SCL is high is a stop. A start at any point, including inside a byte, drops the command in progress and begins a new identification byte. A stop returns the block to idle.
- R2: The identification byte is taken MSB first and accepted only when bits 7:4 equal 0101, bit 3 is 0 and bits 2:0 equal `dev_addr_i`. An accepted byte is acknowledged by pulling SDA low for the ninth clock. A rejected byte is never acknowledged, and the block ignores the bus until the next start.
- R3: In the instruction byte, bits 7:4 are the opcode, bits 3:2 select a register and bits 1:0 select a bank. When a command is accepted, `reg_sel_o` takes bits 3:2 and `bank_sel_o` takes bits 1:0, and the byte is acknowledged.
- R4: These opcodes are not acknowledged: any opcode other than 1001, 1010, 1011, 1100, 1101, 1110 and 0010, and any wiper command (1001, 1010, 1101, 1110, 0010) with bank bits not 00. After such a byte, no strobe and no acknowledge occur until the next start.
- R5: Opcode 1010 writes the wiper and opcode 1100 writes a data register. The third byte is acknowledged, appears on `wr_data_o`, and is followed at the end of its acknowledge clock by exactly one pulse of `wcr_wr_o` or `dr_wr_o`.
- R6: Opcode 1001 reads the wiper and opcode 1011 reads a data register. One pulse of `wcr_rd_o` or `dr_rd_o` is issued when the instruction byte is accepted. `rd_data_i` is captured at the end of that acknowledge and sent MSB first, each bit driven after an SCL fall. SDA is released for the ninth clock, and the master's acknowledge value has no effect.
- R7: Opcode 1101 (data register to wiper) and opcode 1110 (wiper to data register) are two-byte commands. Each gives one pulse of `xfr_dr_to_wcr_o` or `xfr_wcr_to_dr_o` at the end of the instruction acknowledge, with bank 00 only.
- R8: Opcode 0010 raises `step_mode_o` after its acknowledge. Each later SCL clock gives one pulse when SCL falls: `step_up_o` if SDA was high at the preceding SCL rise, `step_down_o` if it was low. A stop ends the mode and gives no pulse.
- R9: At most one of the command and step strobes is high in any cycle, and each write strobe lasts one cycle.
- R10: After reset, SDA is released, `step_mode_o` is low and all strobes are low.
- R11: The open-drain enable is only asserted while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| dev_addr_i | input | 3 | Strapped device address |
| rd_data_i | input | 8 | Data returned by the register side for a read |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| wcr_rd_o | output | 1 | Wiper read strobe |
| wcr_wr_o | output | 1 | Wiper write strobe |
| dr_rd_o | output | 1 | Data register read strobe |
| dr_wr_o | output | 1 | Data register write strobe |
| xfr_dr_to_wcr_o | output | 1 | Copy data register into wiper |
| xfr_wcr_to_dr_o | output | 1 | Copy wiper into data register |
| step_mode_o | output | 1 | Stepping mode active |
| step_up_o | output | 1 | Move wiper one step up |
| step_down_o | output | 1 | Move wiper one step down |
| wr_data_o | output | 8 | Received write byte |
| reg_sel_o | output | 2 | Register pointer |
| bank_sel_o | output | 2 | Bank pointer |

## Verification
The decoder is driven with full write, read, transfer and stepping transactions, each with its own opcode, register and bank. These patterns show whether pointer fields are taken from the right bit positions and whether the right strobe fires. Identification bytes with a wrong address, a wrong device code or a set zero bit check each compare field on its own. Unlisted opcodes and wiper commands with a nonzero bank separate rejection from acceptance. A start inside a byte, a master acknowledge after a read, and step clocks of both polarities followed by a stop cover the sequencing corner cases.

// File: rtl/dpot_pkg.sv
`timescale 1ns/1ps
package dpot_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  localparam logic [3:0] OP_RD_WCR = 4'b1001;
  localparam logic [3:0] OP_WR_WCR = 4'b1010;
  localparam logic [3:0] OP_RD_DR  = 4'b1011;
  localparam logic [3:0] OP_WR_DR  = 4'b1100;
  localparam logic [3:0] OP_D2W    = 4'b1101;
  localparam logic [3:0] OP_W2D    = 4'b1110;
  localparam logic [3:0] OP_STEP   = 4'b0010;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_RD_WCR, CMD_WR_WCR, CMD_RD_DR,
    CMD_WR_DR, CMD_D2W, CMD_W2D, CMD_STEP
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_ID_ACK, ST_INS, ST_INS_ACK, ST_WDATA,
    ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_STEP, ST_WAIT_STOP
  } st_e;
endpackage

// File: rtl/dpot_bus_sampler.sv
`timescale 1ns/1ps
module dpot_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_i;
          sda_pipe[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe[i] <= 1'b1;
          sda_pipe[i] <= 1'b1;
        end else begin
          scl_pipe[i] <= scl_pipe[i-1];
          sda_pipe[i] <= sda_pipe[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[SYNC_STAGES-1];
      sda_q <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[SYNC_STAGES-1];
  assign sda_o      = sda_pipe[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/dpot_insn_decode.sv
`timescale 1ns/1ps
module dpot_insn_decode
  import dpot_pkg::*;
(
  input  logic [BYTE_W-1:0] insn_i,
  output cmd_e              cmd_o,
  output logic              valid_o
);
  logic wiper_cmd;

  always_comb begin
    cmd_o     = CMD_NONE;
    wiper_cmd = 1'b0;
    unique case (insn_i[7:4])
      OP_RD_WCR: begin cmd_o = CMD_RD_WCR; wiper_cmd = 1'b1; end
      OP_WR_WCR: begin cmd_o = CMD_WR_WCR; wiper_cmd = 1'b1; end
      OP_RD_DR:  cmd_o = CMD_RD_DR;
      OP_WR_DR:  cmd_o = CMD_WR_DR;
      OP_D2W:    begin cmd_o = CMD_D2W; wiper_cmd = 1'b1; end
      OP_W2D:    begin cmd_o = CMD_W2D; wiper_cmd = 1'b1; end
      OP_STEP:   begin cmd_o = CMD_STEP; wiper_cmd = 1'b1; end
      default:   cmd_o = CMD_NONE;
    endcase
    valid_o = (cmd_o != CMD_NONE) && (!wiper_cmd || insn_i[1:0] == 2'b00);
  end
endmodule

// File: rtl/dpot_tx_shift.sv
`timescale 1ns/1ps
module dpot_tx_shift #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_i,
  output logic             msb_o
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[WIDTH-2:0], 1'b1};
  end

  assign msb_o = sh_q[WIDTH-1];
endmodule

// File: rtl/dpot_cmd_decoder.sv
`timescale 1ns/1ps
module dpot_cmd_decoder
  import dpot_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_CODE    = 4'b0101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wcr_rd_o,
  output logic              wcr_wr_o,
  output logic              dr_rd_o,
  output logic              dr_wr_o,
  output logic              xfr_dr_to_wcr_o,
  output logic              xfr_wcr_to_dr_o,
  output logic              step_mode_o,
  output logic              step_up_o,
  output logic              step_down_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [1:0]        reg_sel_o,
  output logic [1:0]        bank_sel_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  st_e  state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] rx_sh_q, rx_byte;
  logic ack_on_q, step_dir_q, tx_msb, tx_load, tx_shift;
  logic id_ok, dec_valid;
  cmd_e cmd_q, dec_cmd;

  dpot_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  assign rx_byte = {rx_sh_q[BYTE_W-2:0], sda_s};
  assign id_ok   = (rx_byte[7:4] == DEV_CODE) && !rx_byte[3] &&
                   (rx_byte[2:0] == dev_addr_i);

  dpot_insn_decode u_decode (.insn_i(rx_byte), .cmd_o(dec_cmd), .valid_o(dec_valid));

  // read byte is captured when the instruction acknowledge ends
  assign tx_load  = (state_q == ST_INS_ACK) && scl_fall && ack_on_q &&
                    (cmd_q == CMD_RD_WCR || cmd_q == CMD_RD_DR);
  assign tx_shift = (state_q == ST_RDATA) && scl_fall;

  dpot_tx_shift #(.WIDTH(BYTE_W)) u_tx (
    .clk_i, .rst_ni, .load_i(tx_load), .data_i(rd_data_i),
    .shift_i(tx_shift), .msb_o(tx_msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= ST_IDLE;
      bit_cnt_q       <= '0;
      rx_sh_q         <= '0;
      ack_on_q        <= 1'b0;
      step_dir_q      <= 1'b0;
      cmd_q           <= CMD_NONE;
      wcr_rd_o        <= 1'b0;
      wcr_wr_o        <= 1'b0;
      dr_rd_o         <= 1'b0;
      dr_wr_o         <= 1'b0;
      xfr_dr_to_wcr_o <= 1'b0;
      xfr_wcr_to_dr_o <= 1'b0;
      step_up_o       <= 1'b0;
      step_down_o     <= 1'b0;
      wr_data_o       <= '0;
      reg_sel_o       <= '0;
      bank_sel_o      <= '0;
    end else begin
      wcr_rd_o        <= 1'b0;
      wcr_wr_o        <= 1'b0;
      dr_rd_o         <= 1'b0;
      dr_wr_o         <= 1'b0;
      xfr_dr_to_wcr_o <= 1'b0;
      xfr_wcr_to_dr_o <= 1'b0;
      step_up_o       <= 1'b0;
      step_down_o     <= 1'b0;
      if (start_det) begin
        state_q   <= ST_ID;
        bit_cnt_q <= '0;
        ack_on_q  <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        ack_on_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ID: if (scl_rise) begin
            rx_sh_q   <= rx_byte;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) state_q <= id_ok ? ST_ID_ACK : ST_WAIT_STOP;
          end
          ST_ID_ACK: if (scl_fall) begin
            ack_on_q <= !ack_on_q;
            if (ack_on_q) state_q <= ST_INS;
          end
          ST_INS: if (scl_rise) begin
            rx_sh_q   <= rx_byte;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) begin
              if (dec_valid) begin
                state_q    <= ST_INS_ACK;
                cmd_q      <= dec_cmd;
                reg_sel_o  <= rx_byte[3:2];
                bank_sel_o <= rx_byte[1:0];
                wcr_rd_o   <= (dec_cmd == CMD_RD_WCR);
                dr_rd_o    <= (dec_cmd == CMD_RD_DR);
              end else begin
                state_q <= ST_WAIT_STOP;
              end
            end
          end
          ST_INS_ACK: if (scl_fall) begin
            ack_on_q <= !ack_on_q;
            if (ack_on_q) begin
              unique case (cmd_q)
                CMD_WR_WCR, CMD_WR_DR: state_q <= ST_WDATA;
                CMD_RD_WCR, CMD_RD_DR: state_q <= ST_RDATA;
                CMD_D2W: begin xfr_dr_to_wcr_o <= 1'b1; state_q <= ST_WAIT_STOP; end
                CMD_W2D: begin xfr_wcr_to_dr_o <= 1'b1; state_q <= ST_WAIT_STOP; end
                CMD_STEP: state_q <= ST_STEP;
                default:  state_q <= ST_WAIT_STOP;
              endcase
            end
          end
          ST_WDATA: if (scl_rise) begin
            rx_sh_q   <= rx_byte;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) begin
              wr_data_o <= rx_byte;
              state_q   <= ST_WDATA_ACK;
            end
          end
          ST_WDATA_ACK: if (scl_fall) begin
            ack_on_q <= !ack_on_q;
            if (ack_on_q) begin
              wcr_wr_o <= (cmd_q == CMD_WR_WCR);
              dr_wr_o  <= (cmd_q == CMD_WR_DR);
              state_q  <= ST_WAIT_STOP;
            end
          end
          ST_RDATA: if (scl_fall) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == LAST_BIT) state_q <= ST_RDATA_ACK;
          end
          ST_RDATA_ACK: if (scl_fall) state_q <= ST_WAIT_STOP;
          ST_STEP: begin
            if (scl_rise) step_dir_q <= sda_s;
            if (scl_fall) begin
              step_up_o   <= step_dir_q;
              step_down_o <= !step_dir_q;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = ack_on_q | ((state_q == ST_RDATA) & ~tx_msb);
  assign step_mode_o = (state_q == ST_STEP);
endmodule

// File: rtl/dpot_cmd_decoder_chk.sv
`timescale 1ns/1ps
module dpot_cmd_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       sda_oe_o,
  input logic       wcr_rd_o,
  input logic       wcr_wr_o,
  input logic       dr_rd_o,
  input logic       dr_wr_o,
  input logic       xfr_dr_to_wcr_o,
  input logic       xfr_wcr_to_dr_o,
  input logic       step_mode_o,
  input logic       step_up_o,
  input logic       step_down_o,
  input logic [1:0] bank_sel_o
);
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wcr_rd_o, wcr_wr_o, dr_rd_o, dr_wr_o, xfr_dr_to_wcr_o,
              xfr_wcr_to_dr_o, step_up_o, step_down_o})); // R9
  AST_WCR_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcr_wr_o |=> !wcr_wr_o); // R9
  AST_DR_WR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_wr_o |=> !dr_wr_o); // R9
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_s)); // R11
  AST_STEP_IN_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_up_o || step_down_o) |-> step_mode_o); // R8
  AST_WIPER_BANK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcr_rd_o || wcr_wr_o || xfr_dr_to_wcr_o || xfr_wcr_to_dr_o) |->
    bank_sel_o == 2'b00); // R4
endmodule

bind dpot_cmd_decoder dpot_cmd_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .wcr_rd_o(wcr_rd_o), .wcr_wr_o(wcr_wr_o), .dr_rd_o(dr_rd_o), .dr_wr_o(dr_wr_o),
  .xfr_dr_to_wcr_o(xfr_dr_to_wcr_o), .xfr_wcr_to_dr_o(xfr_wcr_to_dr_o),
  .step_mode_o(step_mode_o), .step_up_o(step_up_o), .step_down_o(step_down_o),
  .bank_sel_o(bank_sel_o)
);

// File: tb/dpot_cmd_decoder_bench.sv
`timescale 1ns/1ps
module dpot_cmd_decoder_bench;
  localparam int QTR = 40;
  localparam logic [2:0] ADDR = 3'b101;
  localparam logic [7:0] IDB  = 8'h55;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [7:0] rd_data;
  logic sda_oe, wcr_rd, wcr_wr, dr_rd, dr_wr, x_d2w, x_w2d, smode, sup, sdn;
  logic [7:0] wr_data;
  logic [1:0] reg_sel, bank_sel;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0;
  int n_wcr_wr = 0, n_dr_wr = 0, n_wcr_rd = 0, n_dr_rd = 0, n_d2w = 0, n_w2d = 0;
  int n_up = 0, n_dn = 0, n_multi = 0, n_oe_bad = 0;
  logic oe_prev = 1'b0;
  logic [7:0] wcr_m, rd_src;
  logic [7:0] dr_m [16];

  always #2 clk = ~clk;

  dpot_cmd_decoder u_dpot_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .dev_addr_i(ADDR),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe), .wcr_rd_o(wcr_rd), .wcr_wr_o(wcr_wr),
    .dr_rd_o(dr_rd), .dr_wr_o(dr_wr), .xfr_dr_to_wcr_o(x_d2w), .xfr_wcr_to_dr_o(x_w2d),
    .step_mode_o(smode), .step_up_o(sup), .step_down_o(sdn), .wr_data_o(wr_data),
    .reg_sel_o(reg_sel), .bank_sel_o(bank_sel)
  );

  assign rd_data = rd_src;

  // register-side model and strobe counters
  always @(posedge clk) begin
    if (!rst_n) begin
      wcr_m <= 8'h00;
      rd_src <= 8'h00;
      for (int i = 0; i < 16; i++) dr_m[i] <= 8'h00;
    end else begin
      if (wcr_rd) rd_src <= wcr_m;
      if (dr_rd)  rd_src <= dr_m[{bank_sel, reg_sel}];
      if (wcr_wr) wcr_m <= wr_data;
      if (dr_wr)  dr_m[{bank_sel, reg_sel}] <= wr_data;
      if (x_d2w)  wcr_m <= dr_m[{2'b00, reg_sel}];
      if (x_w2d)  dr_m[{2'b00, reg_sel}] <= wcr_m;
      if (sup && wcr_m != 8'hFF) wcr_m <= wcr_m + 8'd1;
      if (sdn && wcr_m != 8'h00) wcr_m <= wcr_m - 8'd1;
      n_wcr_wr <= n_wcr_wr + int'(wcr_wr);
      n_dr_wr  <= n_dr_wr + int'(dr_wr);
      n_wcr_rd <= n_wcr_rd + int'(wcr_rd);
      n_dr_rd  <= n_dr_rd + int'(dr_rd);
      n_d2w    <= n_d2w + int'(x_d2w);
      n_w2d    <= n_w2d + int'(x_w2d);
      n_up     <= n_up + int'(sup);
      n_dn     <= n_dn + int'(sdn);
      if ((int'(wcr_rd) + int'(wcr_wr) + int'(dr_rd) + int'(dr_wr) + int'(x_d2w) +
           int'(x_w2d) + int'(sup) + int'(sdn)) > 1) n_multi <= n_multi + 1;
      oe_prev <= sda_oe;
      if (sda_oe && !oe_prev && scl) n_oe_bad <= n_oe_bad + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #QTR; scl = 1'b1; #QTR; sda_m = 1'b0; #QTR; scl = 1'b0; #QTR;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #QTR; scl = 1'b1; #QTR; sda_m = 1'b1; #QTR;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; #QTR; scl = 1'b1; #(2*QTR); scl = 1'b0; #QTR;
  endtask

  task automatic clock_bit(output logic b);
    sda_m = 1'b1; #QTR; scl = 1'b1; #QTR; b = sda_line; #QTR; scl = 1'b0; #QTR;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    clock_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin clock_bit(b); v[i] = b; end
    send_bit(mack);
  endtask

  task automatic read_cmd(input logic [7:0] insn, output logic [7:0] v);
    logic a;
    bus_start(); send_byte(IDB, a); send_byte(insn, a);
    recv_byte(v, 1'b1); bus_stop();
  endtask

  task automatic t_reset();
    chk("R10 oe idle", int'(sda_oe), 0);
    chk("R10 step mode", int'(smode), 0);
    chk("R10 strobes", int'(wcr_rd | wcr_wr | dr_rd | dr_wr | x_d2w | x_w2d | sup | sdn), 0);
  endtask

  task automatic t_write_wcr();
    logic a1, a2, a3;
    int w0 = n_wcr_wr;
    bus_start(); send_byte(IDB, a1); send_byte(8'hA0, a2); send_byte(8'h5A, a3); bus_stop();
    chk("R2 id ack", int'(a1), 1);
    chk("R3 insn ack", int'(a2), 1);
    chk("R5 data ack", int'(a3), 1);
    chk("R5 wr_data", int'(wr_data), 'h5A);
    chk("R5 one wcr write pulse", n_wcr_wr - w0, 1);
  endtask

  task automatic t_read_wcr();
    logic [7:0] v;
    int r0 = n_wcr_rd;
    read_cmd(8'h90, v);
    chk("R6 wcr read data", int'(v), 'h5A);
    chk("R6 wcr read strobe", n_wcr_rd - r0, 1);
    chk("R6 sda released after read", int'(sda_oe), 0);
  endtask

  task automatic t_dr_rw();
    logic a1, a2, a3;
    logic [7:0] v;
    int w0 = n_dr_wr;
    bus_start(); send_byte(IDB, a1); send_byte(8'hC6, a2); send_byte(8'hC3, a3); bus_stop();
    chk("R3 reg_sel field 3:2", int'(reg_sel), 1);
    chk("R3 bank_sel field 1:0", int'(bank_sel), 2);
    chk("R5 dr write pulse", n_dr_wr - w0, 1);
    read_cmd(8'hB6, v);
    chk("R6 dr read bank2 reg1", int'(v), 'hC3);
    read_cmd(8'hB4, v);
    chk("R6 dr read bank0 reg1", int'(v), 0);
    // master acknowledges the read byte: no effect
    bus_start(); send_byte(IDB, a1); send_byte(8'hB6, a2); recv_byte(v, 1'b0);
    chk("R6 oe released after master ack", int'(sda_oe), 0);
    bus_stop();
    chk("R6 read with master ack", int'(v), 'hC3);
  endtask

  task automatic t_id_reject();
    logic a1, a2;
    bus_start(); send_byte(8'h54, a1); send_byte(8'h90, a2); bus_stop();
    chk("R2 wrong address no ack", int'(a1), 0);
    chk("R2 ignored after reject", int'(a2), 0);
    bus_start(); send_byte(8'h5D, a1); bus_stop();
    chk("R2 zero bit set no ack", int'(a1), 0);
    bus_start(); send_byte(8'h75, a1); bus_stop();
    chk("R2 wrong code no ack", int'(a1), 0);
  endtask

  task automatic t_reject();
    logic a1, a2, a3;
    logic [7:0] v;
    int w0 = n_wcr_wr;
    bus_start(); send_byte(IDB, a1); send_byte(8'h00, a2); send_byte(8'h11, a3); bus_stop();
    chk("R4 unlisted opcode no ack", int'(a2), 0);
    chk("R4 no data ack after reject", int'(a3), 0);
    bus_start(); send_byte(IDB, a1); send_byte(8'hA1, a2); send_byte(8'h11, a3); bus_stop();
    chk("R4 wiper write bank1 no ack", int'(a2), 0);
    bus_start(); send_byte(IDB, a1); send_byte(8'h22, a2); bus_stop();
    chk("R4 step bank2 no ack", int'(a2), 0);
    chk("R4 no wcr write", n_wcr_wr - w0, 0);
    read_cmd(8'h90, v);
    chk("R4 wiper unchanged", int'(v), 'h5A);
  endtask

  task automatic t_xfr();
    logic a1, a2, a3;
    logic [7:0] v;
    int d0, w0;
    bus_start(); send_byte(IDB, a1); send_byte(8'hC8, a2); send_byte(8'h33, a3); bus_stop();
    d0 = n_d2w;
    bus_start(); send_byte(IDB, a1); send_byte(8'hD8, a2); bus_stop();
    chk("R7 d2w ack", int'(a2), 1);
    chk("R7 d2w pulse", n_d2w - d0, 1);
    read_cmd(8'h90, v);
    chk("R7 wiper after d2w", int'(v), 'h33);
    w0 = n_w2d;
    bus_start(); send_byte(IDB, a1); send_byte(8'hEC, a2); bus_stop();
    chk("R7 w2d pulse", n_w2d - w0, 1);
    read_cmd(8'hBC, v);
    chk("R7 dr3 after w2d", int'(v), 'h33);
    bus_start(); send_byte(IDB, a1); send_byte(8'hD9, a2); bus_stop();
    chk("R7 transfer bank1 no ack", int'(a2), 0);
  endtask

  task automatic t_step();
    logic a1, a2;
    logic [7:0] v;
    int u0 = n_up, d0 = n_dn;
    bus_start(); send_byte(IDB, a1); send_byte(8'h20, a2);
    chk("R8 step ack", int'(a2), 1);
    chk("R8 step mode on", int'(smode), 1);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    bus_stop();
    chk("R8 up pulses", n_up - u0, 3);
    chk("R8 down pulses, none on stop", n_dn - d0, 2);
    chk("R8 mode ends at stop", int'(smode), 0);
    read_cmd(8'h90, v);
    chk("R8 wiper after steps", int'(v), 'h34);
  endtask

  task automatic t_restart();
    logic a1, a2, a3;
    logic [7:0] v;
    int w0 = n_wcr_wr;
    bus_start(); send_byte(IDB, a1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start(); send_bit(1'b0); send_bit(1'b1);
    bus_start(); send_byte(IDB, a1); send_byte(8'hA0, a2); send_byte(8'h77, a3); bus_stop();
    chk("R1 ack after restart", int'(a1 & a2 & a3), 1);
    chk("R1 single write after restarts", n_wcr_wr - w0, 1);
    read_cmd(8'h90, v);
    chk("R1 wiper after restart", int'(v), 'h77);
  endtask

  initial begin
    #21 rst_n = 1'b1;
    #40;
    t_reset();
    t_write_wcr();
    t_read_wcr();
    t_dr_rw();
    t_id_reject();
    t_reject();
    t_xfr();
    t_step();
    t_restart();
    #40;
    chk("R9 strobes never overlap", n_multi, 0);
    chk("R11 oe rises with SCL low", n_oe_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule